// File: doc/BRIEF.md
# Shared-Multiple Sign-Magnitude Multiplier

This block forms the product of a 17-bit two's-complement sample and a 17-bit sign-magnitude coefficient without a partial-product array. The sample never enters the block directly. Instead the block receives a bus that carries the eight odd multiples of the sample (1x, 3x, ... 15x), which a surrounding filter computes once and hands to every tap. Each tap then needs only selection, shifting and addition.

The 16-bit coefficient magnitude is cut into four 4-bit groups. Each group drives its own select unit. The unit finds the odd part of the group value, picks the matching multiple from the bus, and shifts it back left by the number of trailing zeros. A zero group contributes nothing. The four select results are weighted by their group position and summed. The coefficient sign is then applied to the sum by complementing it and injecting the sign as a carry into the least significant bit. The result is registered once and presented as a 33-bit two's-complement product.

Top module: `csm_mult`

## Requirements
- R1: While `rst_n` is low, `prod_o` is 0 at every clock edge.
- R2: The coefficient is encoded with bit 16 as the sign (1 = negative) and bits 15:0 as the magnitude. One clock edge after the inputs are applied, `prod_o` equals x * (sign ? -magnitude : magnitude) as a 33-bit two's-complement value.
- R3: The bus `odd_mults_i` holds eight 21-bit two's-complement slots. Slot j sits at bits [21j+20:21j] and carries (2j+1)*x. The product is formed only from these slots, so a bus built from a sample y yields y times the coefficient.
- R4: Coefficient bits [4k+3:4k] form group k (k = 0..3). A group of value n contributes n*x*2^(4k), for every n from 1 to 15 and every group position.
- R5: A group of value zero contributes nothing to the product.
- R6: With sign 0, a nonzero magnitude and a positive sample, the product is positive.
- R7: With sign 1, the product is the exact two's-complement negation of the sign-0 product for the same magnitude and sample.
- R8: A magnitude of zero gives a product of exactly 0 for both sign values, so a negative zero also gives 0.
- R9: The extreme operands x = -65536 and magnitude 65535 give the exact product for both signs, with no wrap in the 33-bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the product register captures on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the product register |
| coef_i | input | 17 | Sign-magnitude coefficient: bit 16 sign, bits 15:0 magnitude |
| odd_mults_i | input | 168 | Eight 21-bit odd multiples of the sample, slot j = (2j+1)x at [21j+20:21j] |
| prod_o | output | 33 | Registered two's-complement product |

## Verification
A vector table mixes positive, negative and zero samples with coefficients whose groups have varied trailing-zero counts. This separates the wrong slot being selected from the wrong shift being applied back. A sweep puts every group value 1 to 15 alone at each of the four positions. It shows whether the per-group alignment and the choice of odd part are right, and a single group that contributes zero would show up here. Sign handling is separated from magnitude handling by running each magnitude with both signs, by the negative-zero case and by the extreme operand pair. Feeding a bus derived from a different sample shows that the product follows the bus and nothing else.

// File: rtl/csm_mult.sv
module csm_mult #(
  parameter int XW   = 17,
  parameter int CW   = 17,
  parameter int NW   = 4,
  parameter int NODD = 8,
  localparam int MW  = XW + NW,
  localparam int PW  = XW + CW - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        coef_i,
  input  logic [NODD*MW-1:0]   odd_mults_i,
  output logic [PW-1:0]        prod_o
);

  localparam int MAGW = CW - 1;
  localparam int NNIB = MAGW / NW;
  localparam int SELW = MW + NW - 1;
  localparam int TZW  = (NW > 2) ? $clog2(NW) : 1;
  localparam int IDXW = (NODD > 1) ? $clog2(NODD) : 1;

  logic                   sgn;
  logic [MAGW-1:0]        mag;
  logic signed [SELW-1:0] pp      [NNIB];
  logic [PW-1:0]          aligned [NNIB];
  logic [PW-1:0]          total;
  logic [PW-1:0]          signed_sum;

  assign sgn = coef_i[CW-1];
  assign mag = coef_i[MAGW-1:0];

  for (genvar k = 0; k < NNIB; k++) begin : g_sel
    logic [NW-1:0]   nib;
    logic [TZW-1:0]  tz;
    logic            nz;
    logic [NW-1:0]   odd;
    logic [IDXW-1:0] idx;
    logic [MW-1:0]   base;

    assign nib = mag[k*NW +: NW];
    assign nz  = |nib;

    always_comb begin
      logic found;
      found = 1'b0;
      tz    = '0;
      for (int b = 0; b < NW; b++) begin
        if (!found && nib[b]) begin
          tz    = TZW'(b);
          found = 1'b1;
        end
      end
    end

    assign odd  = nib >> tz;
    assign idx  = IDXW'(odd >> 1);
    assign base = odd_mults_i[idx*MW +: MW];

    assign pp[k] = nz ? ($signed({{(NW-1){base[MW-1]}}, base}) <<< tz) : '0;
    assign aligned[k] = PW'({{(PW-SELW){pp[k][SELW-1]}}, pp[k]}) << (k*NW);

    a_r4_select_unit: assert property (@(posedge clk) disable iff (!rst_n)
      pp[k] == ($signed(odd_mults_i[MW-1:0]) * $signed({{(SELW-NW){1'b0}}, nib})))
      else $error("select unit %0d mismatch", k);
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < NNIB; k++) total = total + aligned[k];
  end

  assign signed_sum = (total ^ {PW{sgn}}) + PW'(sgn);

  always_ff @(posedge clk) begin
    if (!rst_n) prod_o <= '0;
    else        prod_o <= signed_sum;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> prod_o == '0)
    else $error("product not cleared by reset");

  a_r8_zero_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
    (mag == '0) |=> prod_o == '0)
    else $error("zero magnitude gave nonzero product");

  a_r6_r7_sign_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mag != '0 && !odd_mults_i[MW-1] && odd_mults_i[MW-1:0] != '0)
      |=> prod_o[PW-1] == $past(sgn))
    else $error("product sign does not follow coefficient sign");

endmodule

// File: tb/csm_mult_bench.sv
module csm_mult_bench;
  localparam int XW = 17;
  localparam int CW = 17;
  localparam int MW = 21;
  localparam int NODD = 8;
  localparam int PW = 33;
  localparam int NV = 16;

  localparam logic [XW-1:0] VX [NV] = '{
    17'h00001, 17'h00003, 17'h1FFFF, 17'h0FFFF,
    17'h10000, 17'h00ABC, 17'h1F00D, 17'h01234,
    17'h00005, 17'h1FFF0, 17'h07FFF, 17'h08000,
    17'h00000, 17'h15555, 17'h0AAAA, 17'h00100
  };
  localparam logic [CW-1:0] VC [NV] = '{
    17'h00001, 17'h0000F, 17'h00002, 17'h08000,
    17'h0FFFF, 17'h1ABCD, 17'h0C0A0, 17'h18888,
    17'h0F0F0, 17'h10E0E, 17'h1FFFF, 17'h00010,
    17'h1FFFF, 17'h06C6C, 17'h13333, 17'h0A5A5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] coef_i = '0;
  logic [NODD*MW-1:0] odd_mults_i = '0;
  logic [PW-1:0] prod_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csm_mult u_csm_mult (
    .clk(clk), .rst_n(rst_n), .coef_i(coef_i),
    .odd_mults_i(odd_mults_i), .prod_o(prod_o)
  );

  function automatic logic [NODD*MW-1:0] mk_bus(input logic [XW-1:0] x);
    logic [NODD*MW-1:0] b;
    longint xs;
    xs = longint'($signed(x));
    b = '0;
    for (int j = 0; j < NODD; j++) b[j*MW +: MW] = MW'((2*j+1) * xs);
    return b;
  endfunction

  function automatic logic [PW-1:0] model(input logic [XW-1:0] x, input logic [CW-1:0] c);
    longint m;
    m = longint'(c[CW-2:0]);
    if (c[CW-1]) m = -m;
    return PW'(longint'($signed(x)) * m);
  endfunction

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [XW-1:0] x, input logic [CW-1:0] c, input string req);
    logic [PW-1:0] e;
    @(negedge clk);
    coef_i = c;
    odd_mults_i = mk_bus(x);
    e = model(x, c);
    @(negedge clk);
    check(prod_o === e, req, prod_o, e);
  endtask

  initial begin
    odd_mults_i = mk_bus(17'h00123);
    coef_i = 17'h00ABC;
    repeat (3) @(negedge clk);
    check(prod_o === '0, "R1 reset", prod_o, '0);
    rst_n = 1'b1;

    // R2 R4 R5: vector table
    for (int i = 0; i < NV; i++) run(VX[i], VC[i], "R2 table");

    // R4 R5: single group sweep, value n alone at position k
    for (int k = 0; k < 4; k++)
      for (int n = 1; n < 16; n++)
        run(17'h1F3A7, CW'(n << (4*k)), "R4 group sweep");

    // R6 R7: both signs of the same magnitude
    run(17'h00777, 17'h04321, "R6 positive sign");
    check(prod_o[PW-1] == 1'b0, "R6 sign bit", prod_o, model(17'h00777, 17'h04321));
    run(17'h00777, 17'h14321, "R7 negated");

    // R8: zero and negative zero
    run(17'h1ABCD, 17'h00000, "R8 zero");
    run(17'h1ABCD, 17'h10000, "R8 negative zero");
    run(17'h0FFFF, 17'h10000, "R8 negative zero pos x");

    // R9: extreme operands
    run(17'h10000, 17'h0FFFF, "R9 extreme positive coef");
    run(17'h10000, 17'h1FFFF, "R9 extreme negative coef");

    // R3: bus from a different sample than any previous one decides the product
    begin
      logic [PW-1:0] e;
      @(negedge clk);
      coef_i = 17'h00ACE;
      odd_mults_i = mk_bus(17'h00F00);
      e = model(17'h00F00, 17'h00ACE);
      @(negedge clk);
      check(prod_o === e, "R3 bus sample", prod_o, e);
    end

    // R1: reset after a nonzero product
    run(17'h00321, 17'h00123, "R2 before reset");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(prod_o === '0, "R1 mid-run reset", prod_o, '0);
    rst_n = 1'b1;
    run(17'h00321, 17'h00123, "R2 after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule